// File: doc/BRIEF.md
# Superscalar Register Rename Stage

This block renames a group of up to IW instructions in one clock cycle. Each instruction names two source architectural registers and can name one destination. The block translates each source into the physical register that currently holds its value. It gives each real destination a fresh physical register, taken from the head of an external free list. It also reports the physical register that the destination was bound to before, so that later recovery logic can undo the binding.

The mapping lives in a table with one row per architectural register, and each row holds a physical register number. The table read and the comparison of each source against the destinations of older instructions in the same group are both combinational and happen in the same cycle. Where a comparison matches, the newest older writer takes precedence over the stored row. The table takes the group's new bindings at the clock edge that accepts the group.

When the free list cannot cover every destination in the group, the whole group waits under a valid/ready handshake. Register r0 is hardwired to physical register 0 and is never renamed.

Top module: `rename_stage`

## Requirements
- R1: After reset, architectural register k maps to physical register k for every k.
- R2: Architectural register 0 always reads as physical 0. A destination of register 0 allocates nothing: its new and previous tags are 0 and it adds nothing to the pop count.
- R3: A source with no older destination of the same register in its group reads the table row written by previously accepted groups.
- R4: A source that matches older destinations in its own group takes the new tag of the nearest older match.
- R5: The previous tag reported for a destination is the new tag of the nearest older same-group writer of that register. If there is no such writer, it is the table row.
- R6: The k-th live destination of a group, counting from slot 0 upward, gets free-list entry k (field k of fl_tags). fl_pop equals the number of live destinations when the group is accepted.
- R7: When fl_count is less than the number of live destinations, in_ready is low, fl_pop is 0, out_valid is low and the table keeps its contents.
- R8: When several instructions in a group write the same register, the table keeps the tag of the youngest of them.
- R9: Results appear combinationally in the accepting cycle (out_valid = in_valid and in_ready). Bindings from a group are visible to the group accepted in the next cycle.
- R10: An instruction whose destination-enable is low gets new and previous tags of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sets the identity mapping |
| in_valid | input | 1 | A group is offered |
| in_ready | output | 1 | Free list covers the group's destinations |
| in_src1 | input | IW*AW | First source register per slot |
| in_src2 | input | IW*AW | Second source register per slot |
| in_dst | input | IW*AW | Destination register per slot |
| in_dst_en | input | IW | Slot has a destination |
| fl_count | input | CW | Number of free physical registers |
| fl_tags | input | IW*PW | First IW free-list entries, entry 0 in the low field |
| fl_pop | output | FW | Entries consumed at this edge |
| out_valid | output | 1 | Group accepted this cycle |
| out_psrc1 | output | IW*PW | Physical first source per slot |
| out_psrc2 | output | IW*PW | Physical second source per slot |
| out_pdst | output | IW*PW | Newly allocated physical destination per slot |
| out_pold | output | IW*PW | Previous physical binding of the destination |

## Verification
A corrupted table row shows up at the ports the next time any later group reads that register as a source or a destination. That is one cycle after the bad write at the earliest, and it stays visible until the register is written again. Faults in the in-group priority or allocation logic show up at the outputs in the same cycle, through a wrong source tag, a wrong previous tag, or a new tag taken from the wrong free-list field. Stall faults show up as a nonzero pop count while not ready, or as changed rows read out after a refused group.

// File: rtl/rename_pkg.sv
package rename_pkg;
   localparam int unsigned RN_IW_DEF   = 4;
   localparam int unsigned RN_ARCH_DEF = 32;
   localparam int unsigned RN_PHYS_DEF = 64;

   // bit width needed to index n items (at least 1)
   function automatic int unsigned rn_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
   parameter int NUM_ARCH = 32,
   parameter int NUM_PHYS = 64,
   parameter int NRD      = 12,
   parameter int IW       = 4,
   parameter int AW       = 5,
   parameter int PW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_idx [NRD],
   output logic [PW-1:0] rd_tag [NRD],
   input  logic [IW-1:0] wr_en,
   input  logic [AW-1:0] wr_idx [IW],
   input  logic [PW-1:0] wr_tag [IW]
);
   logic [PW-1:0] rows [NUM_ARCH];

   if (NUM_PHYS < NUM_ARCH) begin : g_bad_size
      $error("rename_map_table: fewer physical than architectural registers");
   end

   for (genvar row = 0; row < NUM_ARCH; row++) begin : g_row
      if (row == 0) begin : g_zero
         assign rows[row] = '0;
      end else begin : g_store
         logic [PW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= PW'(row);
            end else begin
               // ascending slot order: youngest matching writer lands last
               for (int j = 0; j < IW; j++) begin
                  if (wr_en[j] && (wr_idx[j] == AW'(row))) q <= wr_tag[j];
               end
            end
         end
         assign rows[row] = q;
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_tag[r] = rows[rd_idx[r]];
   end
endmodule

// File: rtl/rename_alloc.sv
module rename_alloc #(
   parameter int IW = 4,
   parameter int PW = 6,
   parameter int CW = 7,
   parameter int FW = 3
) (
   input  logic [IW-1:0] live,
   input  logic [CW-1:0] fl_count,
   input  logic [PW-1:0] fl_tags [IW],
   output logic [PW-1:0] new_tag [IW],
   output logic [FW-1:0] need,
   output logic          enough
);
   logic [FW-1:0] pre [IW+1];

   assign pre[0] = '0;
   for (genvar i = 0; i < IW; i++) begin : g_slot
      assign pre[i+1]   = pre[i] + FW'(live[i]);
      assign new_tag[i] = live[i] ? fl_tags[pre[i]] : '0;
   end

   assign need   = pre[IW];
   assign enough = (fl_count >= CW'(need));
endmodule

// File: rtl/rename_bypass.sv
module rename_bypass #(
   parameter int IW = 4,
   parameter int AW = 5,
   parameter int PW = 6
) (
   input  logic [AW-1:0] s1      [IW],
   input  logic [AW-1:0] s2      [IW],
   input  logic [AW-1:0] d       [IW],
   input  logic [IW-1:0] live,
   input  logic [PW-1:0] t1      [IW],
   input  logic [PW-1:0] t2      [IW],
   input  logic [PW-1:0] td      [IW],
   input  logic [PW-1:0] new_tag [IW],
   output logic [PW-1:0] ps1     [IW],
   output logic [PW-1:0] ps2     [IW],
   output logic [PW-1:0] pold    [IW]
);
   for (genvar i = 0; i < IW; i++) begin : g_ins
      if (i == 0) begin : g_oldest
         assign ps1[i]  = t1[i];
         assign ps2[i]  = t2[i];
         assign pold[i] = live[i] ? td[i] : '0;
      end else begin : g_younger
         logic [PW-1:0] a, b, o;
         always_comb begin
            a = t1[i];
            b = t2[i];
            o = td[i];
            // later iterations are nearer older slots and override
            for (int j = 0; j < i; j++) begin
               if (live[j] && (d[j] == s1[i])) a = new_tag[j];
               if (live[j] && (d[j] == s2[i])) b = new_tag[j];
               if (live[j] && (d[j] == d[i]))  o = new_tag[j];
            end
         end
         assign ps1[i]  = a;
         assign ps2[i]  = b;
         assign pold[i] = live[i] ? o : '0;
      end
   end
endmodule

// File: rtl/rename_stage.sv
module rename_stage #(
   parameter int IW       = rename_pkg::RN_IW_DEF,
   parameter int NUM_ARCH = rename_pkg::RN_ARCH_DEF,
   parameter int NUM_PHYS = rename_pkg::RN_PHYS_DEF,
   parameter int AW       = rename_pkg::rn_width(NUM_ARCH),
   parameter int PW       = rename_pkg::rn_width(NUM_PHYS),
   parameter int CW       = rename_pkg::rn_width(NUM_PHYS + 1),
   parameter int FW       = rename_pkg::rn_width(IW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [IW*AW-1:0] in_src1,
   input  logic [IW*AW-1:0] in_src2,
   input  logic [IW*AW-1:0] in_dst,
   input  logic [IW-1:0]    in_dst_en,
   input  logic [CW-1:0]    fl_count,
   input  logic [IW*PW-1:0] fl_tags,
   output logic [FW-1:0]    fl_pop,
   output logic             out_valid,
   output logic [IW*PW-1:0] out_psrc1,
   output logic [IW*PW-1:0] out_psrc2,
   output logic [IW*PW-1:0] out_pdst,
   output logic [IW*PW-1:0] out_pold
);
   localparam int NRD = 3 * IW;

   if ((1 << AW) != NUM_ARCH) begin : g_bad_arch
      $error("rename_stage: NUM_ARCH must be a power of two");
   end
   if (NUM_PHYS < NUM_ARCH + IW) begin : g_bad_phys
      $error("rename_stage: NUM_PHYS must cover NUM_ARCH plus one group");
   end
   if (IW < 1) begin : g_bad_iw
      $error("rename_stage: IW must be at least 1");
   end

   logic [AW-1:0] s1 [IW], s2 [IW], d [IW];
   logic [PW-1:0] ft [IW], nt [IW];
   logic [PW-1:0] t1 [IW], t2 [IW], td [IW];
   logic [PW-1:0] ps1 [IW], ps2 [IW], po [IW];
   logic [AW-1:0] rd_idx [NRD];
   logic [PW-1:0] rd_tag [NRD];
   logic [IW-1:0] live, wr_en;
   logic [FW-1:0] need;
   logic          enough, fire;

   for (genvar i = 0; i < IW; i++) begin : g_lane
      assign s1[i]   = in_src1[i*AW +: AW];
      assign s2[i]   = in_src2[i*AW +: AW];
      assign d[i]    = in_dst[i*AW +: AW];
      assign ft[i]   = fl_tags[i*PW +: PW];
      assign live[i] = in_dst_en[i] && (d[i] != '0);

      assign rd_idx[i]        = s1[i];
      assign rd_idx[IW + i]   = s2[i];
      assign rd_idx[2*IW + i] = d[i];
      assign t1[i] = rd_tag[i];
      assign t2[i] = rd_tag[IW + i];
      assign td[i] = rd_tag[2*IW + i];

      assign wr_en[i] = fire && live[i];

      assign out_psrc1[i*PW +: PW] = ps1[i];
      assign out_psrc2[i*PW +: PW] = ps2[i];
      assign out_pdst[i*PW +: PW]  = nt[i];
      assign out_pold[i*PW +: PW]  = po[i];
   end

   rename_alloc #(.IW(IW), .PW(PW), .CW(CW), .FW(FW)) alloc_i (
      .live    (live),
      .fl_count(fl_count),
      .fl_tags (ft),
      .new_tag (nt),
      .need    (need),
      .enough  (enough)
   );

   rename_map_table #(
      .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NRD(NRD),
      .IW(IW), .AW(AW), .PW(PW)
   ) table_i (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_idx(rd_idx),
      .rd_tag(rd_tag),
      .wr_en (wr_en),
      .wr_idx(d),
      .wr_tag(nt)
   );

   rename_bypass #(.IW(IW), .AW(AW), .PW(PW)) bypass_i (
      .s1     (s1),
      .s2     (s2),
      .d      (d),
      .live   (live),
      .t1     (t1),
      .t2     (t2),
      .td     (td),
      .new_tag(nt),
      .ps1    (ps1),
      .ps2    (ps2),
      .pold   (po)
   );

   assign in_ready  = enough;
   assign fire      = in_valid && enough;
   assign out_valid = fire;
   assign fl_pop    = fire ? need : '0;
endmodule

// File: rtl/rename_stage_chk.sv
module rename_stage_chk #(
   parameter int IW = 4, parameter int NUM_ARCH = 32, parameter int NUM_PHYS = 64,
   parameter int AW = 5, parameter int PW = 6, parameter int CW = 7, parameter int FW = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [IW*AW-1:0] in_src1,
   input logic [IW*AW-1:0] in_src2,
   input logic [IW*AW-1:0] in_dst,
   input logic [IW-1:0]    in_dst_en,
   input logic [CW-1:0]    fl_count,
   input logic [IW*PW-1:0] fl_tags,
   input logic [FW-1:0]    fl_pop,
   input logic             out_valid,
   input logic [IW*PW-1:0] out_psrc1,
   input logic [IW*PW-1:0] out_psrc2,
   input logic [IW*PW-1:0] out_pdst,
   input logic [IW*PW-1:0] out_pold
);
   logic [IW-1:0] lv;
   for (genvar i = 0; i < IW; i++) begin : g_lv
      assign lv[i] = in_dst_en[i] && (in_dst[i*AW +: AW] != '0);
   end

   // R7: a refused group consumes nothing and is not reported
   p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |-> (fl_pop == '0 && !out_valid));

   // R6: never pop more than is available
   p_pop_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (CW'(fl_pop) <= fl_count));

   // R6: the oldest live destination takes free-list entry 0
   p_first_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && lv[0]) |-> (out_pdst[PW-1:0] == fl_tags[PW-1:0]));

   // R9: youngest binding of one group reaches the oldest slot of the next
   p_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(out_valid && lv[IW-1]) && out_valid
       && (in_src1[AW-1:0] == $past(in_dst[(IW-1)*AW +: AW])))
      |-> (out_psrc1[PW-1:0] == $past(out_pdst[(IW-1)*PW +: PW])));

   for (genvar i = 0; i < IW; i++) begin : g_ins
      // R2: register 0 reads as physical 0
      p_zero_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && in_src1[i*AW +: AW] == '0 && in_src2[i*AW +: AW] == '0)
         |-> (out_psrc1[i*PW +: PW] == '0 && out_psrc2[i*PW +: PW] == '0));
      // R10: no destination means zero tags
      p_no_dst_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !lv[i]) |-> (out_pdst[i*PW +: PW] == '0 && out_pold[i*PW +: PW] == '0));
      if (i > 0) begin : g_pair
         // R4: adjacent older writer always wins for a matching source
         p_near_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && lv[i-1] && in_src1[i*AW +: AW] == in_dst[(i-1)*AW +: AW])
            |-> (out_psrc1[i*PW +: PW] == out_pdst[(i-1)*PW +: PW]));
         // R5: previous tag comes from the adjacent older writer
         p_near_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && lv[i] && lv[i-1] && in_dst[i*AW +: AW] == in_dst[(i-1)*AW +: AW])
            |-> (out_pold[i*PW +: PW] == out_pdst[(i-1)*PW +: PW]));
      end
   end
endmodule

bind rename_stage rename_stage_chk #(
   .IW(IW), .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS),
   .AW(AW), .PW(PW), .CW(CW), .FW(FW)
) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .in_dst_en(in_dst_en),
   .fl_count(fl_count), .fl_tags(fl_tags), .fl_pop(fl_pop), .out_valid(out_valid),
   .out_psrc1(out_psrc1), .out_psrc2(out_psrc2), .out_pdst(out_pdst), .out_pold(out_pold)
);

// File: tb/rename_stage_tb_top.sv
`timescale 1ns/1ps
module rename_stage_tb_top;
   localparam int IW = 4, NA = 32, NP = 64;
   localparam int AW = 5, PW = 6, CW = 7, FW = 3;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic in_ready, out_valid;
   logic [IW*AW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
   logic [IW-1:0]    in_dst_en = '0;
   logic [CW-1:0]    fl_count = '0;
   logic [IW*PW-1:0] fl_tags = '0;
   logic [FW-1:0]    fl_pop;
   logic [IW*PW-1:0] out_psrc1, out_psrc2, out_pdst, out_pold;

   always #2.5 clk = ~clk;

   rename_stage dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .in_dst_en(in_dst_en),
      .fl_count(fl_count), .fl_tags(fl_tags), .fl_pop(fl_pop), .out_valid(out_valid),
      .out_psrc1(out_psrc1), .out_psrc2(out_psrc2), .out_pdst(out_pdst), .out_pold(out_pold)
   );

   typedef struct packed { logic [PW-1:0] ps1, ps2, pd, old; } item_t;
   item_t exp_q[$];
   string tag_q[$];
   int    errors = 0, checks = 0;
   int    map_m [NA];
   int    free_q[$];
   int    b_s1 [IW], b_s2 [IW], b_d [IW];
   bit    b_en [IW];

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // monitor: compare each accepted group against the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         for (int i = 0; i < IW; i++) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected accepted group", 1, 0);
            end else begin
               item_t e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(out_psrc1[i*PW +: PW] == e.ps1, t, $sformatf("slot%0d psrc1", i),
                     out_psrc1[i*PW +: PW], e.ps1);
               check(out_psrc2[i*PW +: PW] == e.ps2, t, $sformatf("slot%0d psrc2", i),
                     out_psrc2[i*PW +: PW], e.ps2);
               check(out_pdst[i*PW +: PW] == e.pd, t, $sformatf("slot%0d pdst", i),
                     out_pdst[i*PW +: PW], e.pd);
               check(out_pold[i*PW +: PW] == e.old, t, $sformatf("slot%0d pold", i),
                     out_pold[i*PW +: PW], e.old);
            end
         end
      end
   end

   // driver: offer one group, predict results from the requirements
   task automatic run_bundle(input string tag, input int limit);
      int avail, need, k;
      int tmp [NA];
      item_t it;
      @(posedge clk); #0.5;
      avail = free_q.size();
      if (limit >= 0 && limit < avail) avail = limit;
      fl_count = CW'(avail);
      for (int i = 0; i < IW; i++) begin
         fl_tags[i*PW +: PW] = (i < free_q.size()) ? PW'(free_q[i]) : '0;
         in_src1[i*AW +: AW] = AW'(b_s1[i]);
         in_src2[i*AW +: AW] = AW'(b_s2[i]);
         in_dst[i*AW +: AW]  = AW'(b_d[i]);
         in_dst_en[i]        = b_en[i];
      end
      in_valid = 1'b1;
      need = 0;
      for (int i = 0; i < IW; i++) if (b_en[i] && b_d[i] != 0) need++;
      if (need <= avail) begin
         tmp = map_m;
         k = 0;
         for (int i = 0; i < IW; i++) begin
            it.ps1 = PW'(tmp[b_s1[i]]);
            it.ps2 = PW'(tmp[b_s2[i]]);
            it.pd  = '0;
            it.old = '0;
            if (b_en[i] && b_d[i] != 0) begin
               it.old = PW'(tmp[b_d[i]]);
               it.pd  = PW'(free_q[k]);
               tmp[b_d[i]] = free_q[k];
               k++;
            end
            exp_q.push_back(it);
            tag_q.push_back(tag);
         end
         for (int i = 0; i < need; i++) void'(free_q.pop_front());
         // external commit returns the displaced tags
         for (int i = 0; i < IW; i++)
            if (b_en[i] && b_d[i] != 0) free_q.push_back(int'(exp_q[exp_q.size()-IW+i].old));
         map_m = tmp;
      end
      #0.5;
      check(in_ready == (need <= avail), tag, "in_ready", in_ready, need <= avail);
      check(int'(fl_pop) == ((need <= avail) ? need : 0), tag, "fl_pop",
            fl_pop, (need <= avail) ? need : 0);
   endtask

   task automatic set_slot(input int i, input int s1, input int s2, input int d, input bit en);
      b_s1[i] = s1; b_s2[i] = s2; b_d[i] = d; b_en[i] = en;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int k = 0; k < NA; k++) map_m[k] = k;
      for (int k = NA; k < NP; k++) free_q.push_back(k);
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: identity mapping after reset, every register read once
      for (int b = 0; b < NA / IW; b++) begin
         for (int i = 0; i < IW; i++) set_slot(i, b*IW + i, NA-1 - (b*IW + i), 0, 1'b0);
         run_bundle("R1", -1);
      end
      // R2: register 0 sources and destinations
      for (int i = 0; i < IW; i++) set_slot(i, 0, 0, 0, 1'b1);
      run_bundle("R2", -1);
      // R6: four distinct destinations take entries 0..3 in order
      for (int i = 0; i < IW; i++) set_slot(i, 1, 2, 20 + i, 1'b1);
      run_bundle("R6", -1);
      // R3: sources not touched inside the group read the table
      for (int i = 0; i < IW; i++) set_slot(i, 20 + i, 10 + i, 14 + i, 1'b1);
      run_bundle("R3", -1);
      // R4: chained in-group dependences, nearest older writer wins
      set_slot(0, 3, 4, 5, 1'b1);
      set_slot(1, 5, 5, 5, 1'b1);
      set_slot(2, 5, 7, 0, 1'b0);
      set_slot(3, 5, 6, 6, 1'b1);
      run_bundle("R4", -1);
      // R5: repeated writer of one register
      set_slot(0, 1, 1, 9, 1'b1);
      set_slot(1, 9, 2, 9, 1'b1);
      set_slot(2, 2, 9, 9, 1'b1);
      set_slot(3, 3, 3, 8, 1'b1);
      run_bundle("R5", -1);
      // R8: table holds the youngest of the repeated writers
      for (int i = 0; i < IW; i++) set_slot(i, 9, 5, 0, 1'b0);
      run_bundle("R8", -1);
      // R10: slots without destination enable
      set_slot(0, 9, 8, 11, 1'b1);
      set_slot(1, 11, 8, 12, 1'b0);
      set_slot(2, 12, 11, 13, 1'b1);
      set_slot(3, 13, 12, 15, 1'b0);
      run_bundle("R10", -1);
      // R7: group needing three entries refused with only two free
      set_slot(0, 1, 2, 24, 1'b1);
      set_slot(1, 24, 2, 25, 1'b1);
      set_slot(2, 25, 24, 26, 1'b1);
      set_slot(3, 0, 0, 0, 1'b0);
      run_bundle("R7", 2);
      for (int i = 0; i < IW; i++) set_slot(i, 24 + i, 23 - i, 0, 1'b0);
      run_bundle("R7", -1);
      // R9: binding of one group used by the very next one
      for (int i = 0; i < IW; i++) set_slot(i, 1, 2, 27, 1'b1);
      run_bundle("R9", -1);
      for (int i = 0; i < IW; i++) set_slot(i, 27, 27, 28 + i, 1'b1);
      run_bundle("R9", -1);

      // R4: random groups with occasional short free list
      for (int n = 0; n < 300; n++) begin
         for (int i = 0; i < IW; i++)
            set_slot(i, $urandom_range(0, 7), $urandom_range(0, 7),
                     $urandom_range(0, 7), 1'($urandom_range(0, 1)));
         run_bundle("R4", ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 3)) : -1);
      end

      @(posedge clk); #0.5;
      in_valid = 1'b0;
      repeat (2) @(posedge clk);
      check(exp_q.size() == 0, "R9", "pending groups", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule